// File: doc/BRIEF.md
# Flash Self-Programming Controller

This block is the write and erase engine behind a small controller's program flash. The host first streams instruction words into a row-sized holding buffer over a valid/ready load port. It then picks a target address and an operation through a small register port: program one word, program a whole row, or erase a whole page. The operation only runs if it is preceded by a two-value unlock sequence on a write-only key register.

Once an operation starts, the block raises `busy` for a fixed, parameterised number of wait cycles plus one cycle for each word it writes. The requester stalls on `busy`, and `done` pulses once when `busy` falls. Erase sets every word of a page to all ones. Programming can only clear bits: each target word becomes its old value ANDed with the matching buffer word. The flash array is a behavioural memory of 24-bit words, addressed in words, with a combinational read port.

The load port accepts a word on any cycle where `ld_valid` and `ld_ready` are both high. `ld_ready` is low while `busy` is high and in any cycle where `reg_wr` is high. A producer holds `ld_data` and keeps `ld_valid` asserted until the handshake completes.

Top module: `flash_selfprog`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, `ld_ready` is 1 and `ctrl_rd` reads 0.
- R2: Each accepted load writes the next buffer slot. Slots are filled in order starting from 0 and wrap after slot 63, so a 65th load overwrites slot 0. Every launched operation restarts the slot pointer at 0. `ld_ready` is 0 while `busy` is high.
- R3: Register select 0 is the key register. A write of 0x0055 followed by a write of 0x00AA, with no other accepted write between them, arms the block for one start.
- R4: The key detector drops back to idle in these cases: a wrong key value, or any other accepted write (a register write or a load) between 0x0055 and 0x00AA. A start request made while not armed is ignored and sets `err`.
- R5: Any start request uses up the armed state. A second start needs a fresh key sequence.
- R6: Register select 1 is the control register. Bit 15 is the start bit. Bits 1:0 select the operation: 01 is word program, 10 is row program, 11 is page erase. A start while armed with op 00 runs nothing and sets `err`. `ctrl_rd` returns the start bit in bit 15 (high exactly while `busy`) and the operation in bits 1:0.
- R7: Register select 2 is the word address. Row program ignores the low 6 address bits and page erase ignores the low 9, so rows are 64 words and pages are 512 words, both aligned from address 0.
- R8: Page erase sets all 512 words of the addressed page to 0xFFFFFF and leaves every other word unchanged.
- R9: Row program sets word base+i to old AND slot i, for i from 0 to 63. Word program sets word A to old AND slot (A mod 64). No other word changes.
- R10: `busy` rises in the cycle after the accepted start write. It stays high for OP_CYCLES+N cycles, where N is 1, 64 or 512 for word, row or page. `done` is high for exactly the first cycle after `busy` falls.
- R11: While `busy` is high, register writes of any kind are ignored. This covers the key, the address and the control register.
- R12: `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 key, 1 control, 2 address, 3 unused |
| reg_wdata | input | 16 | Register write data |
| ld_valid | input | 1 | Load word valid |
| ld_ready | output | 1 | Load word accepted when high with valid |
| ld_data | input | 24 | Instruction word for the holding buffer |
| rd_addr | input | 10 | Array read word address |
| rd_data | output | 24 | Array read data (combinational) |
| busy | output | 1 | Operation in progress; requester stalls |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky rejected-start flag |
| ctrl_rd | output | 16 | Control register read-back |

## Verification
The hardest states to reach from the ports are key sequences that are almost valid. Examples are a correct 0x55/0xAA pair split by a single buffer load or address write, a correct pair written while an erase is still running, and a start issued right after a valid start has used up the key. The bench builds each of these from explicit register-write and load tasks. It resets between cases so that the sticky flag isolates each one. It then confirms at the ports that `busy` never rose, that `err` was set and that the full array still matches its arithmetic model. Wrap-around of the holding buffer is reached by streaming 65 loads before a row program.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WORD  = 2'b01,
    OP_ROW   = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SEL_KEY  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam logic [15:0] KEY_FIRST  = 16'h0055;
  localparam logic [15:0] KEY_SECOND = 16'h00AA;
  localparam int          START_BIT  = 15;
endpackage

// File: rtl/fsp_key_unlock.sv
module fsp_key_unlock
  import fsp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        any_wr,
  input  logic        key_wr,
  input  logic [15:0] wdata,
  input  logic        consume,
  output logic        armed
);
  typedef enum logic [1:0] {K_IDLE, K_HALF, K_ARMED} kst_e;
  kst_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= K_IDLE;
    end else if (consume) begin
      st <= K_IDLE;
    end else if (any_wr) begin
      unique case (st)
        K_IDLE:  st <= (key_wr && wdata == KEY_FIRST) ? K_HALF : K_IDLE;
        K_HALF:  st <= (key_wr && wdata == KEY_SECOND) ? K_ARMED : K_IDLE;
        K_ARMED: begin
          if (key_wr) st <= (wdata == KEY_FIRST) ? K_HALF : K_IDLE;
        end
        default: st <= K_IDLE;
      endcase
    end
  end

  assign armed = (st == K_ARMED);
endmodule

// File: rtl/fsp_hold_buf.sv
module fsp_hold_buf #(
  parameter int ROW_WORDS = 64,
  parameter int WORD_W    = 24,
  localparam int SLOT_W   = $clog2(ROW_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              restart,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] store [ROW_WORDS];
  logic [SLOT_W-1:0] wptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
    end else if (restart) begin
      wptr <= '0;
    end else if (push) begin
      wptr <= (wptr == SLOT_W'(ROW_WORDS - 1)) ? '0 : wptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wptr] <= push_data;
  end

  assign rd_data = store[rd_slot];
endmodule

// File: rtl/fsp_seq.sv
module fsp_seq
  import fsp_pkg::*;
#(
  parameter int ROW_WORDS  = 64,
  parameter int PAGE_WORDS = 512,
  parameter int OP_CYCLES  = 16,
  parameter int ADDR_W     = 10,
  localparam int SLOT_W    = $clog2(ROW_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  op_e               op,
  input  logic [ADDR_W-1:0] base,
  output logic              busy,
  output logic              done,
  output logic              we,
  output logic              erase,
  output logic [ADDR_W-1:0] waddr,
  output logic [SLOT_W-1:0] slot
);
  localparam int IDX_W = $clog2(PAGE_WORDS);
  localparam int CNT_W = $clog2(OP_CYCLES + 1);
  localparam logic [ADDR_W-1:0] ROW_MASK  = ~ADDR_W'(ROW_WORDS - 1);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~ADDR_W'(PAGE_WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SWEEP} sst_e;
  sst_e              st;
  op_e               op_q;
  logic [ADDR_W-1:0] base_q, base_al;
  logic [IDX_W-1:0]  idx, last_q, last_n;
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    unique case (op)
      OP_ERASE: begin base_al = base & PAGE_MASK; last_n = IDX_W'(PAGE_WORDS - 1); end
      OP_ROW:   begin base_al = base & ROW_MASK;  last_n = IDX_W'(ROW_WORDS - 1);  end
      default:  begin base_al = base;             last_n = '0;                     end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_NONE;
      base_q <= '0;
      last_q <= '0;
      idx    <= '0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (launch) begin
          op_q   <= op;
          base_q <= base_al;
          last_q <= last_n;
          cnt    <= '0;
          st     <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt == CNT_W'(OP_CYCLES - 1)) begin
            idx <= '0;
            st  <= S_SWEEP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SWEEP: begin
          if (idx == last_q) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy  = (st != S_IDLE);
  assign we    = (st == S_SWEEP);
  assign erase = (op_q == OP_ERASE);
  assign waddr = base_q + ADDR_W'(idx);
  assign slot  = (op_q == OP_WORD) ? base_q[SLOT_W-1:0] : idx[SLOT_W-1:0];
endmodule

// File: rtl/flash_selfprog.sv
module flash_selfprog
  import fsp_pkg::*;
#(
  parameter int WORD_W        = 24,
  parameter int ROW_WORDS     = 64,
  parameter int ROWS_PER_PAGE = 8,
  parameter int NUM_PAGES     = 2,
  parameter int OP_CYCLES     = 16,
  localparam int PAGE_WORDS   = ROW_WORDS * ROWS_PER_PAGE,
  localparam int TOTAL_WORDS  = PAGE_WORDS * NUM_PAGES,
  localparam int ADDR_W       = $clog2(TOTAL_WORDS),
  localparam int SLOT_W       = $clog2(ROW_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [15:0]       reg_wdata,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [15:0]       ctrl_rd
);
  logic              wr_ok, ld_push, start_req, launch, key_armed, mem_we, mem_erase;
  logic [ADDR_W-1:0] addr_q, mem_waddr;
  logic [1:0]        ctrl_op;
  logic [SLOT_W-1:0] buf_slot;
  logic [WORD_W-1:0] buf_data;
  logic [WORD_W-1:0] arr [TOTAL_WORDS];
  sel_e              sel;

  assign sel       = sel_e'(reg_sel);
  assign wr_ok     = reg_wr && !busy;
  assign ld_ready  = !busy && !reg_wr;
  assign ld_push   = ld_valid && ld_ready;
  assign start_req = wr_ok && sel == SEL_CTRL && reg_wdata[START_BIT];
  assign launch    = start_req && key_armed && reg_wdata[1:0] != OP_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      ctrl_op <= '0;
      err     <= 1'b0;
    end else begin
      if (wr_ok && sel == SEL_ADDR) addr_q  <= reg_wdata[ADDR_W-1:0];
      if (wr_ok && sel == SEL_CTRL) ctrl_op <= reg_wdata[1:0];
      if (start_req && !launch)     err     <= 1'b1;
    end
  end

  fsp_key_unlock u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_wr  (wr_ok || ld_push),
    .key_wr  (wr_ok && sel == SEL_KEY),
    .wdata   (reg_wdata),
    .consume (start_req),
    .armed   (key_armed)
  );

  fsp_hold_buf #(.ROW_WORDS(ROW_WORDS), .WORD_W(WORD_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ld_push),
    .push_data (ld_data),
    .restart   (launch),
    .rd_slot   (buf_slot),
    .rd_data   (buf_data)
  );

  fsp_seq #(
    .ROW_WORDS (ROW_WORDS),
    .PAGE_WORDS(PAGE_WORDS),
    .OP_CYCLES (OP_CYCLES),
    .ADDR_W    (ADDR_W)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .launch(launch),
    .op    (op_e'(reg_wdata[1:0])),
    .base  (addr_q),
    .busy  (busy),
    .done  (done),
    .we    (mem_we),
    .erase (mem_erase),
    .waddr (mem_waddr),
    .slot  (buf_slot)
  );

  always_ff @(posedge clk) begin
    if (mem_we) arr[mem_waddr] <= mem_erase ? '1 : (arr[mem_waddr] & buf_data);
  end

  assign rd_data = arr[rd_addr];
  assign ctrl_rd = {busy, 13'd0, ctrl_op};
endmodule

// File: rtl/fsp_checks.sv
module fsp_checks (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic ld_ready,
  input logic launch,
  input logic armed,
  input logic mem_we
);
  a_r2_no_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_ready);
  a_r3_launch_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> armed);
  a_r5_key_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !armed);
  a_r10_busy_follows_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);
  a_r10_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_no_launch_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);
  a_r9_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind flash_selfprog fsp_checks u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .ld_ready(ld_ready),
  .launch  (launch),
  .armed   (key_armed),
  .mem_we  (mem_we)
);

// File: tb/flash_selfprog_test.sv
module flash_selfprog_test;
  localparam int OPC = 16;
  localparam int NW  = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [23:0] ld_data = '0;
  logic [9:0]  rd_addr = '0;
  logic [23:0] rd_data;
  logic        busy, done, err;
  logic [15:0] ctrl_rd;

  int checks = 0;
  int failures = 0;
  logic [23:0] exp_mem [NW];
  logic [23:0] exp_buf [64];
  int bptr = 0;

  always #5 clk = ~clk;

  flash_selfprog #(.OP_CYCLES(OPC)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_data(ld_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .err(err), .ctrl_rd(ctrl_rd)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bptr = 0;
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic load_word(input logic [23:0] d);
    @(negedge clk); ld_valid = 1'b1; ld_data = d;
    while (!ld_ready) @(negedge clk);
    @(negedge clk); ld_valid = 1'b0;
    exp_buf[bptr] = d;
    bptr = (bptr + 1) % 64;
  endtask

  task automatic load_row(input logic [23:0] seed, input int n);
    for (int i = 0; i < n; i++) load_word(24'(i * 24'h00A5C3) ^ seed);
  endtask

  task automatic unlock();
    reg_write(2'd0, 16'h0055);
    reg_write(2'd0, 16'h00AA);
  endtask

  task automatic compare_all(input string tag);
    int bad = 0;
    int first = -1;
    for (int a = 0; a < NW; a++) begin
      rd_addr = 10'(a); #1;
      if (rd_data !== exp_mem[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    end
    check(bad == 0, tag, bad, 0);
    if (first >= 0) $display("  first mismatch at word %0d", first);
  endtask

  // op: 1 word, 2 row, 3 erase; starts with current address register
  task automatic start_and_run(input logic [1:0] op, input int addr, input string tag);
    int n, cyc, base;
    n = (op == 2'd3) ? 512 : (op == 2'd2) ? 64 : 1;
    reg_write(2'd1, {1'b1, 13'd0, op});
    check(busy === 1'b1, {tag, " R10 busy rises"}, busy, 1);
    check(ctrl_rd === {1'b1, 13'd0, op}, {tag, " R6 ctrl read-back while busy"}, ctrl_rd, {1'b1, 13'd0, op});
    check(ld_ready === 1'b0, {tag, " R2 ld_ready low while busy"}, ld_ready, 0);
    cyc = 0;
    while (busy && cyc < 2000) begin cyc++; @(negedge clk); end
    check(cyc == OPC + n, {tag, " R10 busy length"}, cyc, OPC + n);
    check(done === 1'b1, {tag, " R10 done pulse"}, done, 1);
    check(ctrl_rd[15] === 1'b0, {tag, " R6 start bit cleared"}, ctrl_rd, 0);
    @(negedge clk);
    check(done === 1'b0, {tag, " R10 done one cycle"}, done, 0);
    if (op == 2'd3) begin
      base = addr & ~511;
      for (int i = 0; i < 512; i++) exp_mem[base + i] = 24'hFFFFFF;
    end else if (op == 2'd2) begin
      base = addr & ~63;
      for (int i = 0; i < 64; i++) exp_mem[base + i] = exp_mem[base + i] & exp_buf[i];
    end else begin
      exp_mem[addr] = exp_mem[addr] & exp_buf[addr % 64];
    end
    bptr = 0;
  endtask

  task automatic run_op(input logic [1:0] op, input int addr, input string tag);
    reg_write(2'd2, 16'(addr));
    unlock();
    start_and_run(op, addr, tag);
  endtask

  task automatic expect_rejected(input logic [1:0] op, input string tag);
    reg_write(2'd1, {1'b1, 13'd0, op});
    check(busy === 1'b0, {tag, " R4 no launch"}, busy, 0);
    check(err === 1'b1, {tag, " R4 err set"}, err, 1);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    @(negedge clk);
    check(busy === 0 && done === 0 && err === 0, "R1 status after reset", {busy, done, err}, 0);
    check(ld_ready === 1'b1, "R1 ld_ready after reset", ld_ready, 1);
    check(ctrl_rd === 16'd0, "R1 ctrl_rd after reset", ctrl_rd, 0);

    // R8 R7 R3: erase both pages using unaligned addresses
    run_op(2'd3, 5, "erase p0");
    run_op(2'd3, 600, "erase p1");
    compare_all("R8 erase all ones");

    // R2 R9 row program on row 3 from an unaligned address
    load_row(24'h5A3C0F, 64);
    run_op(2'd2, 3 * 64 + 17, "row3");
    compare_all("R9 row program");

    // R9 word program: slot 700 mod 64 = 60
    load_row(24'hF0F00F, 64);
    run_op(2'd1, 700, "word700");
    compare_all("R9 word program");

    // R9 AND semantics on a second pass over row 3
    load_row(24'h33CC99, 64);
    run_op(2'd2, 192, "row3 again");
    compare_all("R9 program clears bits only");

    // R2 wrap: 65 loads, slot 0 overwritten
    load_row(24'h0ACE81, 65);
    run_op(2'd2, 640, "row10 wrap");
    compare_all("R2 buffer wrap");

    // R4: start without key
    do_reset();
    expect_rejected(2'd3, "no key");
    // R4: wrong first value
    do_reset();
    reg_write(2'd0, 16'h0056); reg_write(2'd0, 16'h00AA);
    expect_rejected(2'd3, "bad first");
    // R4: address write between the key values
    do_reset();
    reg_write(2'd0, 16'h0055); reg_write(2'd2, 16'd0); reg_write(2'd0, 16'h00AA);
    expect_rejected(2'd3, "addr between");
    // R4: buffer load between the key values
    do_reset();
    reg_write(2'd0, 16'h0055); load_word(24'h000000); reg_write(2'd0, 16'h00AA);
    expect_rejected(2'd3, "load between");
    // R6: armed start with op 00
    do_reset();
    unlock();
    reg_write(2'd1, 16'h8000);
    check(busy === 1'b0, "R6 op none no launch", busy, 0);
    check(err === 1'b1, "R6 op none err", err, 1);
    // R5: key used by one start
    do_reset();
    reg_write(2'd2, 16'd1);
    load_row(24'h123456, 2);
    unlock();
    start_and_run(2'd1, 1, "word1");
    check(err === 1'b0, "R5 valid start no err", err, 0);
    expect_rejected(2'd1, "R5 reuse key");
    compare_all("R4 R5 rejected starts leave array");

    // R11: writes during busy ignored
    do_reset();
    reg_write(2'd2, 16'd600);
    unlock();
    reg_write(2'd1, 16'h8003);
    reg_write(2'd2, 16'd0);
    reg_write(2'd0, 16'h0055);
    reg_write(2'd0, 16'h00AA);
    while (busy) @(negedge clk);
    for (int i = 0; i < 512; i++) exp_mem[512 + i] = 24'hFFFFFF;
    bptr = 0;
    expect_rejected(2'd1, "R11 key during busy");
    load_row(24'h7E7E7E, 64);
    unlock();
    start_and_run(2'd2, 600, "R11 address kept");
    compare_all("R11 address write during busy ignored");
    // R12 sticky until reset
    check(err === 1'b1, "R12 err sticky", err, 1);
    do_reset();
    @(negedge clk);
    check(err === 1'b0, "R12 err cleared by reset", err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule